// File: doc/BRIEF.md
# Floppy Controller State-Bit Latch

This block holds the eight control bits of a disk-controller interface. It sits on the lower byte lane of a 16-bit bus and answers to sixteen register addresses. Address bits A12..A9 carry a 4-bit index. The upper three index bits pick one of the eight state bits. The lowest index bit is the value that bit takes. The data bus plays no part: touching an address is enough to change the state, and reads do this exactly as writes do.

Four of the bits are drive phase lines: three control lines and a strobe line. One bit enables the drive and one chooses between the internal and the external drive. The last two bits form a 2-bit mode output. A companion block uses that mode to choose which of its data, status, handshake and mode registers a data access reaches.

The bank takes one update per bus access. The update happens on the first clock in which chip select and the lower data strobe are both low. While both stay low, the bank takes no further update, even if the index changes. The next update needs the access to end and a new one to begin.

Top module: `floppy_state_latch`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears all eight state bits. After it, phase, drive_en, drive_ext and mode all read zero.
- R2: Index bits [3:1] select the state bit and index bit [0] gives its new value. Indices 0..7 therefore clear or set phase[0], phase[1], phase[2] and phase[3] in turn, with even indices clearing and odd indices setting.
- R3: Index 8 clears and index 9 sets drive_en. Index 10 clears drive_ext, which selects the internal drive. Index 11 sets drive_ext, which selects the external drive.
- R4: Indices 12 and 13 clear and set mode[0]. Indices 14 and 15 clear and set mode[1]. mode[1]=0 means read-register mode and mode[1]=1 means write-register mode.
- R5: A cycle with cs_n low but lds_n high changes no state bit.
- R6: A cycle with lds_n low but cs_n high changes no state bit.
- R7: Only the first clock of an access takes effect: the clock at which cs_n and lds_n are both low after a cycle in which they were not. An index change while both stay low has no effect.
- R8: An access changes only the addressed bit. The other seven keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Device select, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| reg_idx | input | 4 | Register index taken from address bits A12..A9 |
| phase | output | 4 | Phase control lines 0..2 and the strobe line (bit 3) |
| drive_en | output | 1 | Drive enable |
| drive_ext | output | 1 | 0 = internal drive, 1 = external drive |
| mode | output | 2 | Register-select mode; bit 1 is the write-mode bit |

## Verification
The hardest case to reach is an index that changes in the middle of a long access. A bus that always ends its cycles never produces it. The bench holds both selects low across several clocks and moves the index to a second register while they are held. It then checks that only the first register took the update. After that it releases the selects and starts a fresh access to show that the second register can still be written.

// File: rtl/fsl_pkg.sv
// Package: shared sizes and bit positions for the floppy state-bit latch.
// Assumes: the state vector is ordered so that index bits [3:1] address it directly.
package fsl_pkg;
    localparam int IDX_W    = 4;
    localparam int NUM_BITS = 1 << (IDX_W - 1);
    localparam int SEL_W    = IDX_W - 1;

    // Bit positions inside the state vector; the decoder relies on this order.
    localparam int B_PH0   = 0;
    localparam int B_PH1   = 1;
    localparam int B_PH2   = 2;
    localparam int B_STRB  = 3;
    localparam int B_EN    = 4;
    localparam int B_EXT   = 5;
    localparam int B_MODE0 = 6;
    localparam int B_MODE1 = 7;

    typedef logic [NUM_BITS-1:0] state_t;
endpackage

// File: rtl/fsl_access_detect.sv
// Module: detects the first clock of a bus access to the latch.
// Assumes: cs_n and lds_n are synchronous to clk; one pulse per access.
module fsl_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic lds_n,
    output logic start
);
    logic active;
    logic active_q;

    // Purpose: an access is live while both selects are low.
    always_comb active = !cs_n && !lds_n;

    // Purpose: remember whether the previous cycle was already inside an access.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // Purpose: pulse only on the opening cycle of an access.
    always_comb start = active && !active_q;
endmodule

// File: rtl/fsl_index_decode.sv
// Module: turns a register index into a one-hot bit strobe and the new bit value.
// Assumes: index bits [IDX_W-1:1] pick the bit and bit [0] is the value.
module fsl_index_decode #(
    parameter int IDX_W = fsl_pkg::IDX_W,
    localparam int NB   = 1 << (IDX_W - 1)
) (
    input  logic             start,
    input  logic [IDX_W-1:0] idx,
    output logic [NB-1:0]    wr_sel,
    output logic             wr_val
);
    // Purpose: build the one-hot strobe, empty when no access opens.
    always_comb begin
        wr_sel = '0;
        if (start) wr_sel[idx[IDX_W-1:1]] = 1'b1;
        wr_val = idx[0];
    end
endmodule

// File: rtl/fsl_bit_bank.sv
// Module: the bank of individually writable state flops.
// Assumes: at most one wr_sel bit is high per cycle.
module fsl_bit_bank #(
    parameter int NB = fsl_pkg::NUM_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] wr_sel,
    input  logic          wr_val,
    output logic [NB-1:0] bits
);
    for (genvar g = 0; g < NB; g++) begin : g_bit
        // Purpose: hold one state bit, load it when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n)         bits[g] <= 1'b0;
            else if (wr_sel[g]) bits[g] <= wr_val;
        end
    end
endmodule

// File: rtl/floppy_state_latch.sv
// Module: top of the floppy controller state-bit latch.
// Assumes: reg_idx carries address bits A12..A9 and is valid while cs_n and lds_n are low.
module floppy_state_latch
    import fsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       lds_n,
    input  logic [3:0] reg_idx,
    output logic [3:0] phase,
    output logic       drive_en,
    output logic       drive_ext,
    output logic [1:0] mode
);
    logic            start;
    logic [NUM_BITS-1:0] wr_sel;
    logic            wr_val;
    state_t          bits;

    fsl_access_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .lds_n (lds_n),
        .start (start)
    );

    fsl_index_decode #(.IDX_W(IDX_W)) u_dec (
        .start  (start),
        .idx    (reg_idx),
        .wr_sel (wr_sel),
        .wr_val (wr_val)
    );

    fsl_bit_bank #(.NB(NUM_BITS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .bits   (bits)
    );

    // Purpose: fan the state vector out to named outputs.
    always_comb begin
        phase     = bits[B_STRB:B_PH0];
        drive_en  = bits[B_EN];
        drive_ext = bits[B_EXT];
        mode      = bits[B_MODE1:B_MODE0];
    end
endmodule

// File: rtl/fsl_checker.sv
// Module: assertion checker for floppy_state_latch, attached by bind.
// Assumes: it sees only the ports of the top and keeps its own access tracker.
module fsl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       lds_n,
    input logic [3:0] reg_idx,
    input logic [3:0] phase,
    input logic       drive_en,
    input logic       drive_ext,
    input logic [1:0] mode
);
    logic [7:0] st;
    logic       busy_q;
    logic       opens;

    // Purpose: regroup the outputs in index order.
    always_comb st = {mode, drive_ext, drive_en, phase};

    // Purpose: independent record of whether the bus was mid-access.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= (cs_n == 1'b0) && (lds_n == 1'b0);
    end

    always_comb opens = (cs_n == 1'b0) && (lds_n == 1'b0) && !busy_q;

    // R2, R3, R4: the addressed bit takes index bit 0.
    p_target_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        opens |=> st[$past(reg_idx[3:1])] == $past(reg_idx[0]));

    // R8: no more than one bit moves per access.
    p_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        opens |=> $countones(st ^ $past(st)) <= 1);

    // R5, R6, R7: without an opening cycle the state holds.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !opens |=> $stable(st));

    // R4: index 15 enters write-register mode.
    p_write_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opens && reg_idx == 4'hF) |=> mode[1]);
endmodule

bind floppy_state_latch fsl_checker u_fsl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .lds_n     (lds_n),
    .reg_idx   (reg_idx),
    .phase     (phase),
    .drive_en  (drive_en),
    .drive_ext (drive_ext),
    .mode      (mode)
);

// File: tb/floppy_state_latch_test.sv
`timescale 1ns/1ps
module floppy_state_latch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       lds_n = 1'b1;
    logic [3:0] reg_idx = 4'h0;
    logic [3:0] phase;
    logic       drive_en;
    logic       drive_ext;
    logic [1:0] mode;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_st = 8'h00;

    floppy_state_latch uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .lds_n(lds_n), .reg_idx(reg_idx),
        .phase(phase), .drive_en(drive_en), .drive_ext(drive_ext), .mode(mode)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] observed();
        return {mode, drive_ext, drive_en, phase};
    endfunction

    task automatic check(input string req);
        n_tests++;
        if (observed() !== exp_st) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, observed(), exp_st);
        end
    endtask

    // One access: drive at a falling edge, hold for 'hold' cycles, release.
    task automatic access(input logic [3:0] idx, input bit cs_on, input bit lds_on, input int hold);
        @(negedge clk);
        reg_idx = idx;
        cs_n    = !cs_on;
        lds_n   = !lds_on;
        repeat (hold) @(negedge clk);
        cs_n  = 1'b1;
        lds_n = 1'b1;
        if (cs_on && lds_on) exp_st[idx[3:1]] = idx[0];
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_st = 8'h00;
        check("R1 reset state");
    endtask

    task automatic t_phase();
        for (int i = 0; i < 8; i++) begin
            access(4'(i | 1), 1, 1, 1);
            check("R2 phase set");
        end
        for (int i = 0; i < 8; i += 2) begin
            access(4'(i), 1, 1, 1);
            check("R2 phase clear");
        end
    endtask

    task automatic t_drive();
        access(4'd9, 1, 1, 1);  check("R3 enable on");
        access(4'd11, 1, 1, 1); check("R3 external drive");
        access(4'd10, 1, 1, 1); check("R3 internal drive");
        access(4'd8, 1, 1, 1);  check("R3 enable off");
    endtask

    task automatic t_mode();
        access(4'd13, 1, 1, 1); check("R4 mode 01");
        access(4'd15, 1, 1, 1); check("R4 mode 11");
        access(4'd12, 1, 1, 1); check("R4 mode 10");
        access(4'd14, 1, 1, 1); check("R4 mode 00");
    endtask

    task automatic t_no_strobe();
        access(4'd9, 1, 0, 2);  check("R5 strobe inactive");
        access(4'd3, 0, 1, 2);  check("R6 select inactive");
    endtask

    task automatic t_held_access();
        // Open on index 13, move to 15 while held: only mode[0] may change.
        @(negedge clk);
        reg_idx = 4'd13; cs_n = 1'b0; lds_n = 1'b0;
        @(negedge clk);
        reg_idx = 4'd15;
        repeat (3) @(negedge clk);
        exp_st[6] = 1'b1;
        check("R7 index change while held");
        cs_n = 1'b1; lds_n = 1'b1;
        access(4'd15, 1, 1, 1);
        check("R7 fresh access after release");
    endtask

    task automatic t_isolation();
        for (int i = 1; i < 16; i += 2) access(4'(i), 1, 1, 1);
        check("R8 all bits set");
        access(4'd4, 1, 1, 1);
        check("R8 only addressed bit cleared");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_st = 8'h00;
        check("R1 reset after activity");
    endtask

    initial begin
        t_reset();
        t_phase();
        t_drive();
        t_mode();
        t_no_strobe();
        t_held_access();
        t_isolation();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule